// File: doc/BRIEF.md
# Interrupt Vector Offset Generator

This block works out the byte offset of the exception entry point used when an external interrupt is taken by a processor with a coprocessor-0 style control set. It looks at the interrupt-vectoring enable in the cause word and at the pending lines. It also looks at the boot-vector flag and the enable mask in the status word, and at the two vectoring capability flags. From these it picks one of three results. The first is a fixed legacy offset. The second is a spacing-scaled slot found by a masked priority search. The third is a slot whose number an external interrupt controller supplies directly.

The block holds two software-visible registers. One is the interrupt-control word, whose only writable field is the 5-bit vector spacing in bits 9:5, counted in 32-byte units. The other is the exception-base word, whose writable bits are 29:12. A single write port updates either register through a fixed per-register mask.

The exception sequencer pulses `req` for one cycle. On the next clock edge the block registers the offset and raises `vec_valid` for one cycle. The offset then stays put until the next request. Adding the offset to a base address is the job of the sequencer.

Top module: `intvec_offset_gen`

## Requirements
- R1: With `cause_iv` low, the offset delivered for a request is 0x180, whatever the other inputs are.
- R2: With `cause_iv` high and `status_bev` high, the offset is 0x200.
- R3: With `cause_iv` high and the spacing field (`ctl_q[9:5]`) equal to zero, the offset is 0x200.
- R4: With `cause_iv` high, BEV low and nonzero spacing, but neither `vint_cap` nor `veic_cap` set, the offset is 0x200.
- R5: In internal vectored mode (`vint_cap` high, `veic_cap` low), the pending bits are ANDed with `status_mask`. The slot number is the index of the highest remaining bit, or 0 if no bit remains. The offset is 0x200 + slot × spacing × 32.
- R6: When `veic_cap` is high (with or without `vint_cap`), the slot number is `cause_pend` taken as an unsigned number with no masking, and the offset follows the R5 formula.
- R7: A write with `reg_wr_sel`=0 changes only `ctl_q` bits 9:5. All other `ctl_q` bits read 0, and `base_q` is unchanged.
- R8: A write with `reg_wr_sel`=1 changes only `base_q` bits 29:12. All other `base_q` bits keep their value, and `ctl_q` is unchanged.
- R9: `vec_off` and `vec_valid` update on the first clock edge after `req` is sampled high. `vec_valid` is high for one cycle per single-cycle request. Every offset is a multiple of 32. `vec_off` holds between requests even when the inputs change.
- R10: Synchronous active-high reset clears `ctl_q`, `vec_off` and `vec_valid`, and sets `base_q` to 0x8000_0000.
- R11: When a request and a spacing write land in the same cycle, the offset uses the spacing held before that write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle |
| cause_iv | input | 1 | Interrupt-vectoring enable from the cause word |
| cause_pend | input | 8 | Pending interrupt lines (cause bits 15:8) |
| status_bev | input | 1 | Boot-vector flag |
| status_mask | input | 8 | Interrupt enable mask (status bits 15:8) |
| vint_cap | input | 1 | Internal vectored mode available |
| veic_cap | input | 1 | External controller mode available |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_sel | input | 1 | 0 selects interrupt-control, 1 selects exception-base |
| reg_wr_data | input | 32 | Write data |
| ctl_q | output | 32 | Interrupt-control register |
| base_q | output | 32 | Exception-base register |
| vec_off | output | 18 | Registered vector offset |
| vec_valid | output | 1 | One-cycle pulse marking a new offset |

## Verification
A spacing write and an offset request can share one clock edge. The request reads the spacing field while the write replaces that same field. The bench sets the spacing to a known value, then raises `req` together with a write of a different spacing. It checks two things: the delivered offset matches the old spacing, and `ctl_q` already shows the new one. A second request then confirms that the new spacing is in use.

// File: rtl/intvec_offset_gen.sv
module intvec_offset_gen #(
  parameter int NIRQ  = 8,
  parameter int SPW   = 5,
  parameter int SPLSB = 5,
  parameter int DW    = 32,
  parameter int OFF_W = 18,
  parameter logic [DW-1:0] CTL_MASK  = 32'h0000_03E0,
  parameter logic [DW-1:0] BASE_MASK = 32'h3FFF_F000,
  parameter logic [DW-1:0] BASE_RST  = 32'h8000_0000,
  parameter logic [OFF_W-1:0] LEGACY_OFF = 18'h180,
  parameter logic [OFF_W-1:0] VEC_OFF   = 18'h200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             cause_iv,
  input  logic [NIRQ-1:0]  cause_pend,
  input  logic             status_bev,
  input  logic [NIRQ-1:0]  status_mask,
  input  logic             vint_cap,
  input  logic             veic_cap,
  input  logic             reg_wr_en,
  input  logic             reg_wr_sel,
  input  logic [DW-1:0]    reg_wr_data,
  output logic [DW-1:0]    ctl_q,
  output logic [DW-1:0]    base_q,
  output logic [OFF_W-1:0] vec_off,
  output logic             vec_valid
);

  localparam int STEP_W = SPW + 5;
  localparam logic [DW-1:0] BASE_KEEP = BASE_RST & ~BASE_MASK;

  logic [SPW-1:0]    spacing;
  logic [NIRQ-1:0]   masked;
  logic [NIRQ-1:0]   prio_slot;
  logic [NIRQ-1:0]   slot;
  logic [STEP_W-1:0] step;
  logic [OFF_W-1:0]  scaled;
  logic              use_vec;
  logic [OFF_W-1:0]  next_off;

  assign spacing = ctl_q[SPLSB +: SPW];
  assign masked  = cause_pend & status_mask;

  always_comb begin
    prio_slot = '0;
    for (int i = 0; i < NIRQ; i++)
      if (masked[i]) prio_slot = NIRQ'(i);
  end

  assign slot    = veic_cap ? cause_pend : prio_slot;
  assign step    = {spacing, 5'b0};
  assign scaled  = OFF_W'(slot) * OFF_W'(step);
  assign use_vec = cause_iv && !status_bev && (spacing != '0) && (vint_cap || veic_cap);
  assign next_off = !cause_iv ? LEGACY_OFF : (use_vec ? VEC_OFF + scaled : VEC_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      base_q <= BASE_KEEP;
    end else if (reg_wr_en) begin
      if (!reg_wr_sel) ctl_q  <= (ctl_q  & ~CTL_MASK)  | (reg_wr_data & CTL_MASK);
      else             base_q <= (base_q & ~BASE_MASK) | (reg_wr_data & BASE_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_off   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= req;
      if (req) vec_off <= next_off;
    end
  end

  // R9
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(req));

  // R9
  off_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> $stable(vec_off));

  // R9
  off_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_off[4:0] == 5'd0));

  // R1
  legacy_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !cause_iv) |=> (vec_off == LEGACY_OFF));

  // R2
  boot_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req && cause_iv && status_bev) |=> (vec_off == VEC_OFF));

  // R7
  base_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_sel) |=> $stable(base_q));

  // R8
  ctl_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_wr_sel) |=> $stable(ctl_q));

  // R8
  base_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(base_q & ~BASE_MASK));

endmodule

// File: tb/intvec_offset_gen_tb_top.sv
module intvec_offset_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        cause_iv = 1'b0;
  logic [7:0]  cause_pend = '0;
  logic        status_bev = 1'b0;
  logic [7:0]  status_mask = '0;
  logic        vint_cap = 1'b0;
  logic        veic_cap = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_wr_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] ctl_q, base_q;
  logic [17:0] vec_off;
  logic        vec_valid;

  int checks = 0;
  int errors = 0;
  logic [4:0] sp_model = '0;

  always #10 clk = ~clk;

  intvec_offset_gen dut_i (
    .clk(clk), .rst(rst), .req(req), .cause_iv(cause_iv), .cause_pend(cause_pend),
    .status_bev(status_bev), .status_mask(status_mask), .vint_cap(vint_cap),
    .veic_cap(veic_cap), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .ctl_q(ctl_q), .base_q(base_q),
    .vec_off(vec_off), .vec_valid(vec_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] model(input logic iv, bev, vi, ve,
                                        input logic [4:0] sp, input logic [7:0] pd, mk);
    int n = 0;
    logic [7:0] m = pd & mk;
    if (!iv) return 18'h180;
    if (bev || sp == 0 || !(vi || ve)) return 18'h200;
    if (ve) n = pd;
    else for (int i = 0; i < 8; i++) if (m[i]) n = i;
    return 18'(32'h200 + n * sp * 32);
  endfunction

  task automatic write_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (!sel) sp_model = d[9:5];
  endtask

  task automatic run_req(input string tag, input logic iv, bev, vi, ve,
                         input logic [7:0] pd, mk);
    logic [17:0] exp;
    @(negedge clk);
    cause_iv = iv; status_bev = bev; vint_cap = vi; veic_cap = ve;
    cause_pend = pd; status_mask = mk; req = 1'b1;
    exp = model(iv, bev, vi, ve, sp_model, pd, mk);
    @(negedge clk);
    req = 1'b0;
    chk({tag, " offset"}, 32'(vec_off), 32'(exp));
    chk("R9 valid pulse", 32'(vec_valid), 32'd1);
    cause_iv = ~cause_iv; cause_pend = ~cause_pend;
    @(negedge clk);
    chk("R9 valid drops", 32'(vec_valid), 32'd0);
    chk("R9 offset holds", 32'(vec_off), 32'(exp));
  endtask

  task automatic t_reset;
    chk("R10 ctl reset", ctl_q, 32'h0);
    chk("R10 base reset", base_q, 32'h8000_0000);
    chk("R10 off reset", 32'(vec_off), 32'h0);
    chk("R10 valid reset", 32'(vec_valid), 32'h0);
  endtask

  task automatic t_legacy;
    write_reg(1'b0, 32'h0000_0060);
    run_req("R1 iv low", 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF);
  endtask

  task automatic t_forced;
    run_req("R2 bev", 1'b1, 1'b1, 1'b1, 1'b0, 8'h80, 8'hFF);
    run_req("R4 no cap", 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 8'hFF);
    write_reg(1'b0, 32'h0);
    run_req("R3 zero spacing", 1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 8'hFF);
  endtask

  task automatic t_internal;
    write_reg(1'b0, 32'h0000_0060);
    run_req("R5 masked prio", 1'b1, 1'b0, 1'b1, 1'b0, 8'h26, 8'h07);
    chk("R5 expect 0x2C0", 32'(vec_off), 32'h2C0);
    run_req("R5 none left", 1'b1, 1'b0, 1'b1, 1'b0, 8'hF0, 8'h0F);
    run_req("R5 top line", 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'hFF);
  endtask

  task automatic t_external;
    write_reg(1'b0, 32'h0000_0020);
    run_req("R6 raw vector", 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h00);
    chk("R6 expect 0x16A0", 32'(vec_off), 32'h16A0);
    write_reg(1'b0, 32'hFFFF_FFFF);
    run_req("R6 both caps max", 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h01);
  endtask

  task automatic t_regs;
    logic [31:0] b0;
    b0 = base_q;
    write_reg(1'b0, 32'hFFFF_FC1F);
    chk("R7 ctl only field", ctl_q, 32'h0);
    chk("R7 base untouched", base_q, b0);
    write_reg(1'b0, 32'h1234_5678);
    chk("R7 ctl field", ctl_q, 32'h0000_0260);
    write_reg(1'b1, 32'hFFFF_FFFF);
    chk("R8 base mask", base_q, 32'hBFFF_F000);
    chk("R8 ctl untouched", ctl_q, 32'h0000_0260);
    write_reg(1'b1, 32'h4000_0ABC);
    chk("R8 base clear", base_q, 32'h8000_0000);
  endtask

  task automatic t_same_cycle;
    write_reg(1'b0, 32'h0000_0040);
    @(negedge clk);
    cause_iv = 1'b1; status_bev = 1'b0; vint_cap = 1'b1; veic_cap = 1'b0;
    cause_pend = 8'h08; status_mask = 8'hFF; req = 1'b1;
    reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wr_data = 32'h0000_00E0;
    @(negedge clk);
    req = 1'b0; reg_wr_en = 1'b0;
    chk("R11 old spacing", 32'(vec_off), 32'h200 + 3 * 2 * 32);
    chk("R11 write landed", ctl_q, 32'h0000_00E0);
    sp_model = 5'd7;
    run_req("R11 new spacing", 1'b1, 1'b0, 1'b1, 1'b0, 8'h08, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_legacy();
    t_forced();
    t_internal();
    t_external();
    t_regs();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL R9 watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule